// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirection Unit

This unit watches a group of wire-level interrupt request inputs and turns each activation into a single outbound write message. The message carries a destination address and a data word, and both come from a per-line redirection entry. Every line owns one entry. Each entry holds a mask flag, a trigger-mode flag (edge or level), an input polarity flag, a data value and a destination field. A host programs the entries through an indirect port. It writes a register index to a select offset and then reads or writes the chosen register through a window offset.

Inputs are synchronized and then corrected for polarity. An edge-mode line sends one message for each inactive-to-active transition. A level-mode line sends one message and is then marked in service. It sends nothing further until the host writes an end-of-interrupt whose data matches the entry's data value. If the line is still active at that point, it fires again. Only one message is outstanding at a time, and the outbound side uses a valid/ready handshake. When several lines are ready together, the lowest-numbered line wins.

Top module: `irq_msg_redirect`

## Requirements
- R1: Host writes take effect only at byte offsets 0x00 (select: bits 7:0 become the register index), 0x10 (window: writes the selected register) and 0x40 (end-of-interrupt). `hostRdData` continuously shows the selected register.
- R2: Index 0x01 is a read-only identification word. Bits 7:0 read 0x21, bits 23:16 read the highest line number (7 for eight lines), and all other bits read zero. Window writes to it have no effect.
- R3: Entry n's control word is at index 0x10+2n and its destination word is at 0x11+2n. Control word fields: bit 16 mask, bit 15 level mode, bit 13 active-low, bits 7:0 data value. Destination word: bits 31:16 are stored. All other bits read zero.
- R4: After reset every control word reads 0x00010000 (masked), every destination word reads 0, and indices that are not implemented read 0.
- R5: A message presents `msgAddr` = {destination bits 31:16, 16'h0000} and `msgData` = the zero-extended 8-bit data value of the line that fired.
- R6: A line whose mask bit is set produces no message.
- R7: An unmasked edge-mode line produces exactly one message per inactive-to-active transition of its synchronized input, however long it stays active.
- R8: With the active-low bit set, a low input is the active state.
- R9: A level-mode line produces one message and then none until an end-of-interrupt whose bits 7:0 equal its data value. An end-of-interrupt with any other value has no effect.
- R10: An end-of-interrupt that matches a level-mode line which is still active and unmasked causes a new message for that line.
- R11: When several lines are ready in the same cycle, the lowest-numbered line is sent first.
- R12: `msgValid` stays high, with `msgAddr` and `msgData` unchanged, until `msgReady` is seen. After an accepted message `msgValid` drops for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Contents of the selected register |
| irqIn | input | 8 | Asynchronous interrupt request lines |
| msgValid | output | 1 | Outbound message valid |
| msgReady | input | 1 | Outbound message accepted |
| msgAddr | output | 32 | Outbound message target address |
| msgData | output | 32 | Outbound message data word |

## Verification
Some properties are checked on every cycle. A pending message holds steady while `msgReady` is low, and `msgValid` drops after each acceptance. No message is captured from a masked entry or from a level line that is already in service. Other behaviour only shows up in the bench scenarios. These include the exact message contents and their order under simultaneous requests, a single message per edge, silence after a mismatched end-of-interrupt, re-firing after a matching one while the line is still high, active-low inputs, and the reset and read-only views of the register window.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam logic [7:0] SEL_OFF = 8'h00;
  localparam logic [7:0] WIN_OFF = 8'h10;
  localparam logic [7:0] EOI_OFF = 8'h40;
  localparam logic [7:0] ID_IDX = 8'h01;
  localparam logic [7:0] ENTRY_BASE = 8'h10;
  localparam int MASK_BIT = 16;
  localparam int LEVEL_BIT = 15;
  localparam int POL_BIT = 13;

  typedef struct packed {
    logic selWr;
    logic winWr;
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_msg_datapath.sv
module irq_msg_datapath
  import irq_msg_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W = 8,
  parameter logic [7:0] VERSION = 8'h21,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [LINE_W-1:0]          grantLine,
  input  logic [31:0]                wrData,
  input  logic [NUM_LINES-1:0]       irqIn,
  output logic [NUM_LINES-1:0]       lineActive,
  output logic [NUM_LINES-1:0]       lineMasked,
  output logic [NUM_LINES-1:0]       lineLevel,
  output logic [NUM_LINES*VEC_W-1:0] lineVec,
  output logic [31:0]                rdData,
  output logic [31:0]                msgAddr,
  output logic [31:0]                msgData
);
  localparam int ENTRY_END = 32'(ENTRY_BASE) + 2 * NUM_LINES;

  logic [7:0]           selReg;
  logic [NUM_LINES-1:0] maskReg, levelReg, polReg;
  logic [VEC_W-1:0]     vecReg  [NUM_LINES];
  logic [15:0]          destReg [NUM_LINES];
  logic [NUM_LINES-1:0] sync1, sync2;

  logic [7:0]        idxOff;
  logic [LINE_W-1:0] entryIdx;
  logic              hiSel, winIsEntry;
  logic              unusedBits;

  assign idxOff     = selReg - ENTRY_BASE;
  assign entryIdx   = idxOff[LINE_W:1];
  assign hiSel      = idxOff[0];
  assign winIsEntry = (32'(selReg) >= 32'(ENTRY_BASE)) && (32'(selReg) < ENTRY_END);
  assign unusedBits = ^{idxOff[7:LINE_W+1], wrData[14], wrData[12:VEC_W]};

  // Two-flop synchronizer followed by polarity correction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irqIn;
      sync2 <= sync1;
    end
  end

  assign lineActive = sync2 ^ polReg;
  assign lineMasked = maskReg;
  assign lineLevel  = levelReg;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_vecFlat
    assign lineVec[g*VEC_W +: VEC_W] = vecReg[g];
  end

  // Redirection entries and select register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      maskReg  <= '1;
      levelReg <= '0;
      polReg   <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        vecReg[i]  <= '0;
        destReg[i] <= '0;
      end
    end else begin
      if (strobes.selWr) selReg <= wrData[7:0];
      if (strobes.winWr && winIsEntry) begin
        if (hiSel) begin
          destReg[entryIdx] <= wrData[31:16];
        end else begin
          maskReg[entryIdx]  <= wrData[MASK_BIT];
          levelReg[entryIdx] <= wrData[LEVEL_BIT];
          polReg[entryIdx]   <= wrData[POL_BIT];
          vecReg[entryIdx]   <= wrData[VEC_W-1:0];
        end
      end
    end
  end

  // Window read view
  always_comb begin
    rdData = '0;
    if (selReg == ID_IDX) begin
      rdData[7:0]   = VERSION;
      rdData[23:16] = 8'(NUM_LINES - 1);
    end else if (winIsEntry) begin
      if (hiSel) begin
        rdData[31:16] = destReg[entryIdx];
      end else begin
        rdData[MASK_BIT]   = maskReg[entryIdx];
        rdData[LEVEL_BIT]  = levelReg[entryIdx];
        rdData[POL_BIT]    = polReg[entryIdx];
        rdData[VEC_W-1:0]  = vecReg[entryIdx];
      end
    end
  end

  // Outbound message latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strobes.capture) begin
      msgAddr <= {destReg[grantLine], 16'h0000};
      msgData <= 32'(vecReg[grantLine]);
    end
  end

  AST_MASKED_NO_SEND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> !maskReg[grantLine]); // R6
endmodule

// File: rtl/irq_msg_control.sv
module irq_msg_control
  import irq_msg_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic [7:0]                 hostAddr,
  input  logic [VEC_W-1:0]           eoiData,
  input  logic [NUM_LINES-1:0]       lineActive,
  input  logic [NUM_LINES-1:0]       lineMasked,
  input  logic [NUM_LINES-1:0]       lineLevel,
  input  logic [NUM_LINES*VEC_W-1:0] lineVec,
  input  logic                       msgReady,
  output ctrlStrobes_t               strobes,
  output logic [LINE_W-1:0]          grantLine,
  output logic                       msgValid
);
  logic                 eoiWr, anyReady;
  logic [NUM_LINES-1:0] prevActive, edgePend, inService;
  logic [NUM_LINES-1:0] riseVec, readyVec, grantMask, eoiClr;

  assign strobes.selWr = hostWrEn && (hostAddr == SEL_OFF);
  assign strobes.winWr = hostWrEn && (hostAddr == WIN_OFF);
  assign eoiWr         = hostWrEn && (hostAddr == EOI_OFF);

  assign riseVec  = lineActive & ~prevActive;
  assign readyVec = ~lineMasked &
                    ((lineLevel & lineActive & ~inService) | (~lineLevel & edgePend));
  assign anyReady = |readyVec;

  // Lowest-numbered ready line wins
  always_comb begin
    grantLine = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (readyVec[i]) grantLine = LINE_W'(i);
    end
  end

  assign strobes.capture = anyReady && !msgValid;
  assign grantMask = strobes.capture ? (NUM_LINES'(1) << grantLine) : '0;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_eoi
    assign eoiClr[g] = eoiWr && lineLevel[g] && (lineVec[g*VEC_W +: VEC_W] == eoiData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive <= '0;
      edgePend   <= '0;
      inService  <= '0;
      msgValid   <= 1'b0;
    end else begin
      prevActive <= lineActive;
      edgePend   <= ((edgePend & ~grantMask) | (riseVec & ~lineMasked & ~lineLevel))
                    & ~(lineMasked | lineLevel);
      inService  <= (inService & ~eoiClr) | (grantMask & lineLevel);
      if (strobes.capture) msgValid <= 1'b1;
      else if (msgReady)   msgValid <= 1'b0;
    end
  end

  AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> !inService[grantLine]); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgValid); // R12
endmodule

// File: rtl/irq_msg_redirect.sv
module irq_msg_redirect
  import irq_msg_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W = 8,
  parameter logic [7:0] VERSION = 8'h21,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWrEn,
  input  logic [7:0]           hostAddr,
  input  logic [31:0]          hostWrData,
  output logic [31:0]          hostRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [31:0]          msgAddr,
  output logic [31:0]          msgData
);
  ctrlStrobes_t               strobes;
  logic [LINE_W-1:0]          grantLine;
  logic [NUM_LINES-1:0]       lineActive, lineMasked, lineLevel;
  logic [NUM_LINES*VEC_W-1:0] lineVec;

  irq_msg_datapath #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .VERSION(VERSION)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .grantLine(grantLine),
    .wrData(hostWrData), .irqIn(irqIn), .lineActive(lineActive),
    .lineMasked(lineMasked), .lineLevel(lineLevel), .lineVec(lineVec),
    .rdData(hostRdData), .msgAddr(msgAddr), .msgData(msgData)
  );

  irq_msg_control #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) ctl_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .eoiData(hostWrData[VEC_W-1:0]), .lineActive(lineActive),
    .lineMasked(lineMasked), .lineLevel(lineLevel), .lineVec(lineVec),
    .msgReady(msgReady), .strobes(strobes), .grantLine(grantLine),
    .msgValid(msgValid)
  );

  AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData)); // R12
endmodule

// File: tb/irq_msg_redirect_tb.sv
module irq_msg_redirect_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [7:0]  irqIn = '0;
  logic        msgValid;
  logic        msgReady = 1'b1;
  logic [31:0] msgAddr, msgData;

  int checkCount = 0;
  int failCount = 0;
  int msgCount = 0;
  logic [63:0] sbq[$];

  always #5 clk = ~clk;

  irq_msg_redirect dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irqIn(irqIn),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic readIdx(input logic [7:0] idx, output logic [31:0] v);
    hostWrite(8'h00, {24'h0, idx});
    v = hostRdData;
  endtask

  task automatic cfgLine(input int ln, input logic [31:0] lo, input logic [31:0] hi);
    hostWrite(8'h00, 32'(8'h11 + 2 * ln));
    hostWrite(8'h10, hi);
    hostWrite(8'h00, 32'(8'h10 + 2 * ln));
    hostWrite(8'h10, lo);
  endtask

  task automatic expectMsg(input logic [31:0] a, input logic [31:0] d);
    sbq.push_back({a, d});
  endtask

  task automatic settle(input string req, input int startCount, input int delta);
    repeat (12) @(negedge clk);
    chk({req, " message count"}, 32'(msgCount - startCount), 32'(delta));
    chk({req, " scoreboard drained"}, 32'(sbq.size()), 32'd0);
  endtask

  // Monitor: compare every accepted message against the scoreboard
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      msgCount++;
      checkCount++;
      if (sbq.size() == 0) begin
        failCount++;
        $display("FAIL R6/R7/R9 unexpected message actual=%h/%h expected=none", msgAddr, msgData);
      end else begin
        logic [63:0] e;
        e = sbq.pop_front();
        if ({msgAddr, msgData} !== e) begin
          failCount++;
          $display("FAIL R5/R11 message actual=%h/%h expected=%h/%h",
                   msgAddr, msgData, e[63:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 reset msgValid", {31'h0, msgValid}, 32'h0);

    readIdx(8'h01, v); chk("R2 id word", v, 32'h0007_0021);
    readIdx(8'h10, v); chk("R4 reset ctrl word", v, 32'h0001_0000);
    readIdx(8'h1F, v); chk("R4 reset dest word", v, 32'h0);
    readIdx(8'h05, v); chk("R4 unimplemented low index", v, 32'h0);
    readIdx(8'h20, v); chk("R4 unimplemented high index", v, 32'h0);

    hostWrite(8'h00, 32'h01);
    hostWrite(8'h10, 32'hFFFF_FFFF);
    chk("R2 id read-only", hostRdData, 32'h0007_0021);

    cfgLine(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    readIdx(8'h16, v); chk("R3 ctrl field layout", v, 32'h0001_A0FF);
    readIdx(8'h17, v); chk("R3 dest field layout", v, 32'hFFFF_0000);

    hostWrite(8'h20, 32'h0);
    hostWrite(8'h00, 32'h17);
    hostWrite(8'h30, 32'h1234_5678);
    chk("R1 stray offsets ignored", hostRdData, 32'hFFFF_0000);

    // R7 edge line 3
    cfgLine(3, 32'h0000_0033, 32'h3333_0000);
    base = msgCount;
    expectMsg(32'h3333_0000, 32'h33);
    irqIn[3] = 1'b1;
    settle("R7 first edge", base, 1);
    base = msgCount;
    repeat (10) @(negedge clk);
    chk("R7 no repeat while high", 32'(msgCount - base), 32'd0);
    irqIn[3] = 1'b0;
    repeat (5) @(negedge clk);
    base = msgCount;
    expectMsg(32'h3333_0000, 32'h33);
    irqIn[3] = 1'b1;
    settle("R7 second edge", base, 1);
    irqIn[3] = 1'b0;

    // R6 masked line 0
    base = msgCount;
    irqIn[0] = 1'b1;
    settle("R6 masked line", base, 0);
    irqIn[0] = 1'b0;

    // R9 / R10 level line 1
    cfgLine(1, 32'h0000_8041, 32'hA5C3_0000);
    base = msgCount;
    expectMsg(32'hA5C3_0000, 32'h41);
    irqIn[1] = 1'b1;
    settle("R9 level first", base, 1);
    base = msgCount;
    hostWrite(8'h40, 32'h99);
    settle("R9 mismatched eoi", base, 0);
    base = msgCount;
    expectMsg(32'hA5C3_0000, 32'h41);
    hostWrite(8'h40, 32'h41);
    settle("R10 eoi while asserted", base, 1);
    irqIn[1] = 1'b0;
    repeat (4) @(negedge clk);
    base = msgCount;
    hostWrite(8'h40, 32'h41);
    settle("R9 eoi after release", base, 0);

    // R8 active-low level line 6
    irqIn[6] = 1'b1;
    cfgLine(6, 32'h0000_A066, 32'h6600_0000);
    base = msgCount;
    repeat (6) @(negedge clk);
    chk("R8 high input inactive", 32'(msgCount - base), 32'd0);
    expectMsg(32'h6600_0000, 32'h66);
    irqIn[6] = 1'b0;
    settle("R8 low input fires", base, 1);
    irqIn[6] = 1'b1;
    repeat (4) @(negedge clk);
    base = msgCount;
    hostWrite(8'h40, 32'h66);
    settle("R8 release then eoi", base, 0);

    // R11 / R12 priority with backpressure
    cfgLine(2, 32'h0000_8022, 32'h2200_0000);
    cfgLine(5, 32'h0000_8055, 32'h5500_0000);
    msgReady = 1'b0;
    base = msgCount;
    expectMsg(32'h2200_0000, 32'h22);
    expectMsg(32'h5500_0000, 32'h55);
    irqIn[5] = 1'b1;
    irqIn[2] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R12 valid held", {31'h0, msgValid}, 32'h1);
    chk("R11 lowest line first", msgData, 32'h22);
    chk("R12 address held", msgAddr, 32'h2200_0000);
    msgReady = 1'b1;
    settle("R11 both delivered", base, 2);
    irqIn[2] = 1'b0;
    irqIn[5] = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end
endmodule